// File: doc/BRIEF.md
# Dual 8-bit Event Counter with Cascade

Two 8-bit up-counters run side by side off one system clock. For each channel a 3-bit source code picks the count event: one of three taps of a shared free-running prescaler, an edge of that channel's external clock pin, or an event from the other channel. Through that last choice the pair can be chained into a wider counter.

Each channel has two compare registers. Its outputs show when the counter equals either one. A 2-bit clear mode can return the counter to zero after a compare match or on a rising edge of an external reset pin. On a wrap past 0xFF the channel sets a sticky overflow flag, and that flag is gated with an enable bit to form an interrupt request.

Software sets the mode fields, the compare values and the counter value through a write-only port.

Top module: `tmr8_pair`

## Requirements
- R1: After reset both counters are 0. Counting is stopped (source code 000), clearing is disabled (mode 00), the overflow flags are 0 and the interrupt enables are 0, so both interrupt requests are low.
- R2: A write selects a channel with `wr_ch` and a register with `wr_sel`: 0 is control, 1 is compare A, 2 is compare B, 3 is the counter. In the control byte, bits [2:0] are the source code, bits [4:3] the clear mode, bit 5 the interrupt enable and bit 6 the overflow flag. Writing 0 to bit 6 clears the flag, and writing 1 leaves it unchanged.
- R3: With source code 000 the counter holds its value whatever the external clock does.
- R4: Codes 001, 010 and 011 advance the counter once every 8, 64 and 8192 system clocks. Each step is taken on a 1-to-0 transition of a prescaler bit.
- R5: Codes 101, 110 and 111 advance the counter once per rising edge, once per falling edge, or once per edge of either polarity on the channel's external clock. The pin is synchronized first.
- R6: In clear mode 01 (or 10), a count event that arrives while the counter equals compare A (or B) loads 0 in place of the increment. With compare value N the counter therefore runs 0..N.
- R7: In clear mode 11, a rising edge on the channel's external reset pin clears the counter. In the other modes that pin has no effect.
- R8: A count event that arrives while the counter is 0xFF moves the counter to 0 and sets the overflow flag. The flag stays set until a control write with bit 6 at 0.
- R9: `ovf_irq_o` of a channel is high exactly while its overflow flag and its interrupt enable are both 1.
- R10: With code 100, channel 0 advances once per wrap of channel 1.
- R11: With code 100, channel 1 advances once per compare-A event of channel 0, that is, once per channel 0 count event taken while channel 0 equals compare A.
- R12: When both channels select code 100, neither counter advances.
- R13: `match_a_o` and `match_b_o` of a channel are high whenever that counter equals compare A or compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_sel | input | 2 | Register addressed by the write |
| wr_data | input | 8 | Write data |
| ext_clk_i | input | 2 | External clock pins, one per channel |
| ext_rst_i | input | 2 | External counter-reset pins, one per channel |
| cnt0_o | output | 8 | Channel 0 counter |
| cnt1_o | output | 8 | Channel 1 counter |
| match_a_o | output | 2 | Counter equals compare A, per channel |
| match_b_o | output | 2 | Counter equals compare B, per channel |
| ovf_o | output | 2 | Overflow flag, per channel |
| ovf_irq_o | output | 2 | Overflow interrupt request, per channel |

## Verification
The hardest state to reach from the ports is an overflow produced by the slowest prescaler tap or by the cascade path. The stimulus avoids waiting out long runs by preloading a counter to 0xFE or 0xFF through the counter register, then supplying a few external edges, so that a wrap, or a compare-A event on channel 0, is only one or two events away. The prescaler taps are measured over windows that are exact multiples of the tap period, so the expected count difference does not depend on the prescaler phase.

// File: rtl/tmr8_pair.sv
module tmr8_pair #(
  parameter int W     = 8,
  parameter int PW    = 13,
  parameter int TAP_A = 2,
  parameter int TAP_B = 5,
  parameter int TAP_C = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_ch,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   ext_clk_i,
  input  logic [1:0]   ext_rst_i,
  output logic [W-1:0] cnt0_o,
  output logic [W-1:0] cnt1_o,
  output logic [1:0]   match_a_o,
  output logic [1:0]   match_b_o,
  output logic [1:0]   ovf_o,
  output logic [1:0]   ovf_irq_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [PW-1:0] pre_q, pre_d1;
  logic [2:0]    cks_q [2];
  logic [1:0]    clr_q [2];
  logic [W-1:0]  cnt_q [2];
  logic [W-1:0]  cpa_q [2];
  logic [W-1:0]  cpb_q [2];
  logic [2:0]    xc_s  [2];
  logic [2:0]    xr_s  [2];
  logic [1:0]    ie_q, ovf_q, ovf_ev_q, ma_ev_q;
  logic [1:0]    tick, eq_a, eq_b, wrap, clr_cmp, clr_ext;
  logic          both_cas;

  wire fall_a = pre_d1[TAP_A] & ~pre_q[TAP_A];
  wire fall_b = pre_d1[TAP_B] & ~pre_q[TAP_B];
  wire fall_c = pre_d1[TAP_C] & ~pre_q[TAP_C];

  always_comb begin
    both_cas = (cks_q[0] == 3'd4) && (cks_q[1] == 3'd4);
    for (int c = 0; c < 2; c++) begin
      logic xc_r, xc_f, casc;
      xc_r = xc_s[c][1] & ~xc_s[c][2];
      xc_f = ~xc_s[c][1] & xc_s[c][2];
      casc = (c == 0) ? ovf_ev_q[1] : ma_ev_q[0];
      case (cks_q[c])
        3'd1:    tick[c] = fall_a;
        3'd2:    tick[c] = fall_b;
        3'd3:    tick[c] = fall_c;
        3'd4:    tick[c] = casc & ~both_cas;
        3'd5:    tick[c] = xc_r;
        3'd6:    tick[c] = xc_f;
        3'd7:    tick[c] = xc_r | xc_f;
        default: tick[c] = 1'b0;
      endcase
      eq_a[c]    = (cnt_q[c] == cpa_q[c]);
      eq_b[c]    = (cnt_q[c] == cpb_q[c]);
      wrap[c]    = tick[c] & (cnt_q[c] == TOP);
      clr_cmp[c] = tick[c] & (((clr_q[c] == 2'd1) & eq_a[c]) | ((clr_q[c] == 2'd2) & eq_b[c]));
      clr_ext[c] = (clr_q[c] == 2'd3) & xr_s[c][1] & ~xr_s[c][2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      pre_d1   <= '0;
      ie_q     <= '0;
      ovf_q    <= '0;
      ovf_ev_q <= '0;
      ma_ev_q  <= '0;
      for (int c = 0; c < 2; c++) begin
        cks_q[c] <= '0;
        clr_q[c] <= '0;
        cnt_q[c] <= '0;
        cpa_q[c] <= '1;
        cpb_q[c] <= '1;
        xc_s[c]  <= '0;
        xr_s[c]  <= '0;
      end
    end else begin
      pre_q  <= pre_q + 1'b1;
      pre_d1 <= pre_q;
      for (int c = 0; c < 2; c++) begin
        logic hit;
        hit = wr_en && (wr_ch == c[0]);
        xc_s[c]     <= {xc_s[c][1:0], ext_clk_i[c]};
        xr_s[c]     <= {xr_s[c][1:0], ext_rst_i[c]};
        ovf_ev_q[c] <= wrap[c];
        ma_ev_q[c]  <= tick[c] & eq_a[c];
        if (hit && wr_sel == 2'd0) begin
          cks_q[c] <= wr_data[2:0];
          clr_q[c] <= wr_data[4:3];
          ie_q[c]  <= wr_data[5];
        end
        if (hit && wr_sel == 2'd1) cpa_q[c] <= wr_data;
        if (hit && wr_sel == 2'd2) cpb_q[c] <= wr_data;
        if (hit && wr_sel == 2'd3)          cnt_q[c] <= wr_data;
        else if (clr_ext[c] || clr_cmp[c])  cnt_q[c] <= '0;
        else if (tick[c])                   cnt_q[c] <= cnt_q[c] + 1'b1;
        if (wrap[c])                                         ovf_q[c] <= 1'b1;
        else if (hit && wr_sel == 2'd0 && !wr_data[6])       ovf_q[c] <= 1'b0;
      end
    end
  end

  assign cnt0_o    = cnt_q[0];
  assign cnt1_o    = cnt_q[1];
  assign match_a_o = eq_a;
  assign match_b_o = eq_b;
  assign ovf_o     = ovf_q;
  assign ovf_irq_o = ovf_q & ie_q;

  assert_tap_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_a |-> (pre_q[TAP_A:0] == '0));

  assert_both_cascade_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (both_cas && !wr_en && clr_q[0] != 2'd3 && clr_q[1] != 2'd3)
      |=> ($stable(cnt_q[0]) && $stable(cnt_q[1])));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cks_q[g] == 3'd0 && !wr_en && clr_q[g] != 2'd3) |=> $stable(cnt_q[g]));

    assert_cmp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[g] && clr_q[g] == 2'd1 && eq_a[g] && !wr_en) |=> (cnt_q[g] == '0));

    assert_flag_from_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q[g]) |-> $past(cnt_q[g] == TOP));
  end
endmodule

// File: tb/tmr8_pair_tb.sv
module tmr8_pair_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wr_ch = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] xclk = 0, xrst = 0;
  logic [7:0] cnt0, cnt1;
  logic [1:0] ma, mb, ovf, irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tmr8_pair dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .ext_clk_i(xclk), .ext_rst_i(xrst), .cnt0_o(cnt0),
    .cnt1_o(cnt1), .match_a_o(ma), .match_b_o(mb), .ovf_o(ovf), .ovf_irq_o(irq));

  typedef struct packed {
    logic [2:0]  src;
    logic [1:0]  clr;
    logic [7:0]  ca;
    logic [7:0]  cb;
    logic [15:0] n;
    logic [7:0]  ecnt;
    logic        eovf;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd5, 2'd0, 8'd0,   8'd0, 16'd5,   8'd5, 1'b0},
    '{3'd5, 2'd1, 8'd3,   8'd0, 16'd5,   8'd1, 1'b0},
    '{3'd5, 2'd2, 8'd1,   8'd4, 16'd7,   8'd2, 1'b0},
    '{3'd5, 2'd0, 8'd0,   8'd0, 16'd260, 8'd4, 1'b1},
    '{3'd6, 2'd0, 8'd0,   8'd0, 16'd3,   8'd3, 1'b0},
    '{3'd7, 2'd0, 8'd0,   8'd0, 16'd3,   8'd6, 1'b0},
    '{3'd5, 2'd1, 8'hFF,  8'd0, 16'd256, 8'd0, 1'b1},
    '{3'd7, 2'd2, 8'd0,   8'd2, 16'd4,   8'd2, 1'b0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int sel, int d);
    @(negedge clk);
    wr_en = 1; wr_ch = ch[0]; wr_sel = sel[1:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(int ch, int n);
    for (int i = 0; i < n; i++) begin
      xclk[ch] = 1; repeat (4) @(negedge clk);
      xclk[ch] = 0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic rpulse(int ch);
    xrst[ch] = 1; repeat (4) @(negedge clk);
    xrst[ch] = 0; repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cnt0", cnt0, 0); chk("R1 cnt1", cnt1, 0);
    chk("R1 ovf", ovf, 0);   chk("R1 irq", irq, 0);
    pulse(0, 2);
    chk("R1 stopped after reset", cnt0, 0);

    for (int k = 0; k < 8; k++) begin
      wr(0, 0, 0);
      wr(0, 1, VEC[k].ca);
      wr(0, 2, VEC[k].cb);
      wr(0, 3, 0);
      wr(0, 0, {VEC[k].clr, VEC[k].src});
      pulse(0, VEC[k].n);
      chk($sformatf("R5/R6/R8 vec%0d cnt", k), cnt0, VEC[k].ecnt);
      chk($sformatf("R8 vec%0d ovf", k), ovf[0], VEC[k].eovf);
    end

    // R9: flag 1 from the last wrapping vector is cleared below; recreate it
    wr(0, 0, 0); wr(0, 3, 8'hFF); wr(0, 0, 8'h05);
    pulse(0, 1);
    chk("R8 wrap sets flag", ovf[0], 1);
    chk("R9 irq low while disabled", irq[0], 0);
    wr(0, 0, 8'h65);
    chk("R2 flag write 1 keeps", ovf[0], 1);
    chk("R9 irq high", irq[0], 1);
    wr(0, 0, 8'h25);
    chk("R8 flag cleared", ovf[0], 0);
    chk("R9 irq drops", irq[0], 0);
    wr(0, 0, 8'h65);
    chk("R2 flag write 1 no set", ovf[0], 0);

    // R3
    wr(0, 0, 0); wr(0, 3, 7);
    pulse(0, 3);
    chk("R3 hold", cnt0, 7);

    // R13
    wr(0, 1, 7); wr(0, 2, 9);
    chk("R13 match a", ma[0], 1); chk("R13 match b", mb[0], 0);
    wr(0, 3, 9);
    chk("R13 match a off", ma[0], 0); chk("R13 match b on", mb[0], 1);

    // R7
    wr(0, 0, 8'h1D); wr(0, 3, 0);
    pulse(0, 5);
    chk("R7 pre-clear", cnt0, 5);
    rpulse(0);
    chk("R7 ext clear", cnt0, 0);
    wr(0, 0, 8'h05);
    pulse(0, 3);
    rpulse(0);
    chk("R7 ignored", cnt0, 3);

    // R4
    wr(0, 0, 8'h01); repeat (20) @(negedge clk);
    a = cnt0; repeat (80) @(negedge clk);
    chk("R4 div8", (cnt0 - a) & 8'hFF, 10);
    wr(0, 0, 8'h02); repeat (70) @(negedge clk);
    a = cnt0; repeat (640) @(negedge clk);
    chk("R4 div64", (cnt0 - a) & 8'hFF, 10);
    wr(0, 0, 8'h03); repeat (8200) @(negedge clk);
    a = cnt0; repeat (16384) @(negedge clk);
    chk("R4 div8192", (cnt0 - a) & 8'hFF, 2);

    // R10
    wr(1, 0, 8'h05); wr(1, 3, 8'hFE);
    wr(0, 0, 8'h04); wr(0, 3, 0);
    pulse(1, 2);
    chk("R10 ch1 wrapped", cnt1, 0);
    chk("R10 ch0 cascade", cnt0, 1);

    // R11
    wr(0, 0, 8'h0D); wr(0, 1, 2); wr(0, 3, 0);
    wr(1, 0, 8'h04); wr(1, 3, 0);
    pulse(0, 9);
    chk("R11 ch0 cleared", cnt0, 0);
    chk("R11 ch1 cascade", cnt1, 3);

    // R12
    wr(0, 0, 8'h04); wr(0, 3, 8'h02);
    wr(1, 3, 8'hFF);
    pulse(0, 3); pulse(1, 3);
    chk("R12 ch0 frozen", cnt0, 2);
    chk("R12 ch1 frozen", cnt1, 255);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule